// File: doc/BRIEF.md
# Port Overload Fault Timer

This block watches one powered output port and decides when that port must be switched off. On each millisecond tick it multiplies the digitised output current by the digitised output voltage. It compares the product with a power figure selected by the port's negotiated class. Time spent above that figure charges an integrator. Time spent at or below it drains the integrator at one sixteenth of the charge rate. When the integrator reaches the timeout, the block shuts the port down.

A second, independent guard applies only to the highest class. It counts consecutive milliseconds in which the analog current limiter reports that it is clamping. If the clamp lasts too long, the guard shuts the port down to protect the pass switch. The guard is inactive while the port is still within its power-up window. The block also tells the analog limiter which limit level to use.

The shutdown indication latches. It stays set until the sequencer removes the powered enable, which also clears every timer. The two cause bits tell the sequencer which mechanism tripped.

Top module: `ocp_fault_timer`

## Requirements
- R1: After reset, `shutdown_o` is 0, `cause_o` is 2'b00 and `ilim_code_o` is 425.
- R2: A tick counts as overloaded when `iout_i * vout_i` strictly exceeds the class power times 10000. Units are 1 mA per LSB of `iout_i` and 100 mV per LSB of `vout_i`. The class power is 7 W for class code 2 and 33 W for class code 4. It is 16 W for codes 0, 1, 3 and for the unused codes 5 to 7.
- R3: Starting from an empty integrator, 60 consecutive overloaded ticks set `shutdown_o` on the 60th tick and not before. `cause_o` bit 0 marks this overload trip.
- R4: An overloaded tick adds 16 sub-steps to the integrator and a non-overloaded tick removes 1; the trip point is 960 sub-steps. So 30 overloaded ticks, then 16 quiet ticks, then 31 overloaded ticks trip on the last of those 31 and not on the 30th.
- R5: The integrator does not go below zero. After it has drained empty, any further quiet ticks still leave a full 60 overloaded ticks needed to trip.
- R6: For class code 4 after the power-up window, 15 consecutive ticks with `ilim_active_i` high trip the port on the 15th tick. `cause_o` bit 1 marks this limit trip. A cycle with `ilim_active_i` low restarts the count.
- R7: For any class code other than 4, `ilim_active_i` has no effect on `shutdown_o`.
- R8: Once set, `shutdown_o` and `cause_o` hold while `powered_i` stays high, even when the overload goes away. The first clock edge with `powered_i` low clears both.
- R9: While `powered_i` is low, both timers are held at zero: overloaded ticks seen while unpowered do not count after power is applied.
- R10: `ilim_code_o` is 425 while unpowered and during the first 60 ticks after `powered_i` rises. After that window it is 885 for class code 4 and 425 for every other class code.
- R11: During the power-up window the class-4 limit guard does not count, even with `ilim_active_i` held high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| tick_i | input | 1 | One-cycle pulse every millisecond |
| powered_i | input | 1 | Port is powered; low clears all state |
| class_i | input | 3 | Negotiated class code |
| vout_i | input | 10 | Output voltage, 100 mV per LSB |
| iout_i | input | 10 | Output current, 1 mA per LSB |
| ilim_active_i | input | 1 | Analog current limiter is clamping |
| shutdown_o | output | 1 | Latched request to turn the pass switch off |
| cause_o | output | 2 | Bit 0 overload trip, bit 1 limit-guard trip |
| ilim_code_o | output | 10 | Current-limit setpoint in mA for the analog limiter |

## Verification
The properties assume that `tick_i` is a single-cycle pulse. They also assume that the class, voltage and current codes are steady around each tick. The bench drives every input at the falling edge, and it raises `tick_i` for exactly one clock with one idle clock after it. The checker assumes the sequencer drops `powered_i` to re-arm a tripped port, and the bench power-cycles the port between scenarios for that reason.

// File: rtl/ocp_pkg.sv
package ocp_pkg;

   localparam int CLASS_W = 3;

   localparam logic [CLASS_W-1:0] CLS_LOW_PWR  = 3'd2;
   localparam logic [CLASS_W-1:0] CLS_HIGH_PWR = 3'd4;

   typedef enum logic [1:0] {
      BAND_STD  = 2'd0,
      BAND_LOW  = 2'd1,
      BAND_HIGH = 2'd2
   } pwr_band_e;

   typedef struct packed {
      logic lim;
      logic ovl;
   } cause_t;

   function automatic pwr_band_e band_of(input logic [CLASS_W-1:0] cls);
      pwr_band_e b;
      if (cls == CLS_LOW_PWR)       b = BAND_LOW;
      else if (cls == CLS_HIGH_PWR) b = BAND_HIGH;
      else                          b = BAND_STD;
      return b;
   endfunction

endpackage

// File: rtl/ocp_power_cmp.sv
module ocp_power_cmp
   import ocp_pkg::*;
#(
   parameter int unsigned V_W       = 10,
   parameter int unsigned I_W       = 10,
   parameter int unsigned PWR_SCALE = 10000,
   parameter int unsigned P_STD_W   = 16,
   parameter int unsigned P_LOW_W   = 7,
   parameter int unsigned P_HIGH_W  = 33,
   parameter bit          CMP_REG   = 1'b0
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [CLASS_W-1:0] class_i,
   input  logic [V_W-1:0]     vout_i,
   input  logic [I_W-1:0]     iout_i,
   output logic               over_o
);
   localparam int unsigned PROD_W  = V_W + I_W;
   localparam longint unsigned TH_STD  = longint'(P_STD_W)  * PWR_SCALE;
   localparam longint unsigned TH_LOW  = longint'(P_LOW_W)  * PWR_SCALE;
   localparam longint unsigned TH_HIGH = longint'(P_HIGH_W) * PWR_SCALE;
   localparam longint unsigned PROD_MAX = (longint'(1) << PROD_W) - 1;

   if (TH_STD > PROD_MAX || TH_LOW > PROD_MAX || TH_HIGH > PROD_MAX) begin : g_bad_th
      $error("power threshold does not fit the product width");
   end
   if (V_W == 0 || I_W == 0) begin : g_bad_w
      $error("code widths must be non-zero");
   end

   logic [PROD_W-1:0] prod;
   logic [PROD_W-1:0] thresh;
   logic              over_c;

   always_comb begin
      prod = PROD_W'(vout_i) * PROD_W'(iout_i);
      unique case (band_of(class_i))
         BAND_LOW:  thresh = PROD_W'(TH_LOW);
         BAND_HIGH: thresh = PROD_W'(TH_HIGH);
         default:   thresh = PROD_W'(TH_STD);
      endcase
      over_c = (prod > thresh);
   end

   if (CMP_REG) begin : g_reg
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) over_o <= 1'b0;
         else        over_o <= over_c;
      end
   end else begin : g_comb
      assign over_o = over_c;
   end

endmodule

// File: rtl/ocp_leak_timer.sv
module ocp_leak_timer #(
   parameter int unsigned TIMEOUT_MS = 60,
   parameter int unsigned DOWN_SHIFT = 4
) (
   input  logic clk,
   input  logic rst_n,
   input  logic clr_i,
   input  logic hold_i,
   input  logic tick_i,
   input  logic over_i,
   output logic hit_o
);
   localparam int unsigned LIMIT = TIMEOUT_MS << DOWN_SHIFT;
   localparam int unsigned CNT_W = $clog2(LIMIT + 1);
   localparam int unsigned UP    = 1 << DOWN_SHIFT;

   if (TIMEOUT_MS == 0) begin : g_bad_to
      $error("timeout must be non-zero");
   end
   if (DOWN_SHIFT > 8) begin : g_bad_sh
      $error("leak shift too large");
   end

   logic [CNT_W-1:0] cnt_q;
   logic [CNT_W-1:0] cnt_d;
   logic [CNT_W:0]   sum;

   always_comb begin
      sum   = {1'b0, cnt_q} + (CNT_W+1)'(UP);
      cnt_d = cnt_q;
      if (over_i) begin
         if (sum >= (CNT_W+1)'(LIMIT)) cnt_d = CNT_W'(LIMIT);
         else                          cnt_d = sum[CNT_W-1:0];
      end else if (cnt_q != '0) begin
         cnt_d = cnt_q - 1'b1;
      end
   end

   assign hit_o = tick_i && !hold_i && !clr_i && (cnt_d == CNT_W'(LIMIT));

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                 cnt_q <= '0;
      else if (clr_i)             cnt_q <= '0;
      else if (tick_i && !hold_i) cnt_q <= cnt_d;
   end

endmodule

// File: rtl/ocp_ilim_guard.sv
module ocp_ilim_guard #(
   parameter int unsigned GUARD_MS     = 15,
   parameter int unsigned INRUSH_MS    = 60,
   parameter int unsigned ILIM_W       = 10,
   parameter int unsigned ILIM_STD_MA  = 425,
   parameter int unsigned ILIM_HIGH_MA = 885
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr_i,
   input  logic              hold_i,
   input  logic              tick_i,
   input  logic              high_cls_i,
   input  logic              lim_active_i,
   output logic              hit_o,
   output logic [ILIM_W-1:0] ilim_code_o
);
   localparam int unsigned IN_W = $clog2(INRUSH_MS + 1) + 1;
   localparam int unsigned G_W  = $clog2(GUARD_MS + 1) + 1;

   if (ILIM_HIGH_MA >= (1 << ILIM_W) || ILIM_STD_MA >= (1 << ILIM_W)) begin : g_bad_lim
      $error("limit setpoint does not fit its width");
   end

   logic [IN_W-1:0] in_cnt_q;
   logic            in_window;
   logic            armed;

   assign in_window = (in_cnt_q < IN_W'(INRUSH_MS));
   assign armed     = high_cls_i && !in_window && !clr_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     in_cnt_q <= '0;
      else if (clr_i)                 in_cnt_q <= '0;
      else if (tick_i && in_window)   in_cnt_q <= in_cnt_q + 1'b1;
   end

   assign ilim_code_o = armed ? ILIM_W'(ILIM_HIGH_MA) : ILIM_W'(ILIM_STD_MA);

   if (GUARD_MS == 0) begin : g_no_guard
      assign hit_o = 1'b0;
   end else begin : g_guard
      logic [G_W-1:0] g_cnt_q;
      logic           live;

      assign live  = armed && lim_active_i;
      assign hit_o = tick_i && !hold_i && live && (g_cnt_q == G_W'(GUARD_MS - 1));

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)                  g_cnt_q <= '0;
         else if (!live)              g_cnt_q <= '0;
         else if (tick_i && !hold_i && g_cnt_q < G_W'(GUARD_MS))
                                      g_cnt_q <= g_cnt_q + 1'b1;
      end
   end

endmodule

// File: rtl/ocp_fault_timer.sv
module ocp_fault_timer
   import ocp_pkg::*;
#(
   parameter int unsigned V_W          = 10,
   parameter int unsigned I_W          = 10,
   parameter int unsigned PWR_SCALE    = 10000,
   parameter int unsigned P_STD_W      = 16,
   parameter int unsigned P_LOW_W      = 7,
   parameter int unsigned P_HIGH_W     = 33,
   parameter int unsigned TIMEOUT_MS   = 60,
   parameter int unsigned DOWN_SHIFT   = 4,
   parameter int unsigned GUARD_MS     = 15,
   parameter int unsigned INRUSH_MS    = 60,
   parameter int unsigned ILIM_W       = 10,
   parameter int unsigned ILIM_STD_MA  = 425,
   parameter int unsigned ILIM_HIGH_MA = 885,
   parameter bit          CMP_REG      = 1'b0
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tick_i,
   input  logic              powered_i,
   input  logic [2:0]        class_i,
   input  logic [V_W-1:0]    vout_i,
   input  logic [I_W-1:0]    iout_i,
   input  logic              ilim_active_i,
   output logic              shutdown_o,
   output logic [1:0]        cause_o,
   output logic [ILIM_W-1:0] ilim_code_o
);
   logic   clr;
   logic   over;
   logic   ovl_hit;
   logic   lim_hit;
   logic   faulted;
   cause_t cause_q;

   assign clr     = !powered_i;
   assign faulted = cause_q.ovl || cause_q.lim;

   ocp_power_cmp #(
      .V_W(V_W), .I_W(I_W), .PWR_SCALE(PWR_SCALE),
      .P_STD_W(P_STD_W), .P_LOW_W(P_LOW_W), .P_HIGH_W(P_HIGH_W),
      .CMP_REG(CMP_REG)
   ) u_cmp (
      .clk(clk), .rst_n(rst_n), .class_i(class_i),
      .vout_i(vout_i), .iout_i(iout_i), .over_o(over)
   );

   ocp_leak_timer #(
      .TIMEOUT_MS(TIMEOUT_MS), .DOWN_SHIFT(DOWN_SHIFT)
   ) u_leak (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .hold_i(faulted),
      .tick_i(tick_i), .over_i(over), .hit_o(ovl_hit)
   );

   ocp_ilim_guard #(
      .GUARD_MS(GUARD_MS), .INRUSH_MS(INRUSH_MS), .ILIM_W(ILIM_W),
      .ILIM_STD_MA(ILIM_STD_MA), .ILIM_HIGH_MA(ILIM_HIGH_MA)
   ) u_guard (
      .clk(clk), .rst_n(rst_n), .clr_i(clr), .hold_i(faulted),
      .tick_i(tick_i), .high_cls_i(class_i == CLS_HIGH_PWR),
      .lim_active_i(ilim_active_i), .hit_o(lim_hit), .ilim_code_o(ilim_code_o)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)        cause_q <= '0;
      else if (clr)      cause_q <= '0;
      else if (!faulted) cause_q <= '{lim: lim_hit, ovl: ovl_hit};
   end

   assign shutdown_o = faulted;
   assign cause_o    = cause_q;

endmodule

// File: rtl/ocp_fault_timer_chk.sv
module ocp_fault_timer_chk #(
   parameter int unsigned ILIM_W       = 10,
   parameter int unsigned ILIM_STD_MA  = 425,
   parameter int unsigned ILIM_HIGH_MA = 885
) (
   input logic              clk,
   input logic              rst_n,
   input logic              tick_i,
   input logic              powered_i,
   input logic [2:0]        class_i,
   input logic              ilim_active_i,
   input logic              shutdown_o,
   input logic [1:0]        cause_o,
   input logic [ILIM_W-1:0] ilim_code_o
);
   a_r8_sticky_while_powered: assert property (@(posedge clk) disable iff (!rst_n)
      (shutdown_o && powered_i) |=> shutdown_o);

   a_r9_unpowered_clears: assert property (@(posedge clk) disable iff (!rst_n)
      !powered_i |=> (!shutdown_o && cause_o == 2'b00));

   a_r3_trip_on_tick: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(shutdown_o) |-> $past(tick_i));

   a_r6_limit_trip_class: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(cause_o[1]) |-> ($past(class_i) == 3'd4 && $past(ilim_active_i)));

   a_r10_setpoint_legal: assert property (@(posedge clk) disable iff (!rst_n)
      (ilim_code_o == ILIM_W'(ILIM_STD_MA)) || (ilim_code_o == ILIM_W'(ILIM_HIGH_MA)));

   a_r10_low_after_power_on: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(powered_i) |=> (ilim_code_o == ILIM_W'(ILIM_STD_MA)));

   a_r8_cause_matches: assert property (@(posedge clk) disable iff (!rst_n)
      shutdown_o |-> (cause_o != 2'b00));
endmodule

bind ocp_fault_timer ocp_fault_timer_chk #(
   .ILIM_W(ILIM_W), .ILIM_STD_MA(ILIM_STD_MA), .ILIM_HIGH_MA(ILIM_HIGH_MA)
) u_chk (
   .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .powered_i(powered_i),
   .class_i(class_i), .ilim_active_i(ilim_active_i), .shutdown_o(shutdown_o),
   .cause_o(cause_o), .ilim_code_o(ilim_code_o)
);

// File: tb/ocp_fault_timer_bench.sv
module ocp_fault_timer_bench;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       tick_i = 1'b0;
   logic       powered_i = 1'b0;
   logic [2:0] class_i = 3'd0;
   logic [9:0] vout_i = 10'd500;
   logic [9:0] iout_i = 10'd0;
   logic       ilim_active_i = 1'b0;
   logic       shutdown_o;
   logic [1:0] cause_o;
   logic [9:0] ilim_code_o;

   int n_checks = 0;
   int n_fail = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   ocp_fault_timer u_ocp_fault_timer (
      .clk(clk), .rst_n(rst_n), .tick_i(tick_i), .powered_i(powered_i),
      .class_i(class_i), .vout_i(vout_i), .iout_i(iout_i),
      .ilim_active_i(ilim_active_i), .shutdown_o(shutdown_o),
      .cause_o(cause_o), .ilim_code_o(ilim_code_o)
   );

   task automatic check(input string tag, input int act, input int exp);
      n_checks++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
      end
   endtask

   task automatic ticks(input int n);
      for (int k = 0; k < n; k++) begin
         tick_i = 1'b1;
         @(negedge clk);
         tick_i = 1'b0;
         @(negedge clk);
      end
   endtask

   task automatic repower(input logic [2:0] cls, input logic [9:0] v, input logic [9:0] i);
      powered_i = 1'b0;
      ilim_active_i = 1'b0;
      @(negedge clk);
      class_i = cls; vout_i = v; iout_i = i;
      powered_i = 1'b1;
      @(negedge clk);
   endtask

   task automatic t_reset;
      check("R1 shutdown", shutdown_o, 0);
      check("R1 cause", cause_o, 0);
      check("R1 ilim", ilim_code_o, 425);
   endtask

   task automatic thr_case(input logic [2:0] cls, input logic [9:0] i, input bit trip);
      repower(cls, 10'd500, i);
      ticks(60);
      check($sformatf("R2 class %0d current %0d", cls, i), shutdown_o, trip);
      check("R2 cause", cause_o, trip ? 1 : 0);
   endtask

   task automatic t_threshold;
      thr_case(3'd3, 10'd330, 1'b1);
      thr_case(3'd3, 10'd320, 1'b0);
      thr_case(3'd2, 10'd141, 1'b1);
      thr_case(3'd2, 10'd140, 1'b0);
      thr_case(3'd4, 10'd661, 1'b1);
      thr_case(3'd4, 10'd660, 1'b0);
      thr_case(3'd1, 10'd321, 1'b1);
      thr_case(3'd0, 10'd321, 1'b1);
      thr_case(3'd6, 10'd321, 1'b1);
   endtask

   task automatic t_timeout_edge;
      repower(3'd3, 10'd500, 10'd400);
      ticks(59);
      check("R3 before 60th tick", shutdown_o, 0);
      ticks(1);
      check("R3 on 60th tick", shutdown_o, 1);
      check("R3 cause overload", cause_o, 1);
   endtask

   task automatic t_sticky;
      iout_i = 10'd0;
      ticks(100);
      check("R8 held after overload gone", shutdown_o, 1);
      check("R8 cause held", cause_o, 1);
      powered_i = 1'b0;
      @(negedge clk);
      check("R8 cleared by unpower", shutdown_o, 0);
      check("R8 cause cleared", cause_o, 0);
   endtask

   task automatic t_leak;
      repower(3'd3, 10'd500, 10'd400);
      ticks(30);
      iout_i = 10'd100;
      ticks(16);
      iout_i = 10'd400;
      ticks(30);
      check("R4 not yet after 30+30", shutdown_o, 0);
      ticks(1);
      check("R4 trip after leak", shutdown_o, 1);
   endtask

   task automatic t_floor;
      repower(3'd3, 10'd500, 10'd400);
      ticks(10);
      iout_i = 10'd100;
      ticks(200);
      iout_i = 10'd400;
      ticks(59);
      check("R5 floor, 59 ticks", shutdown_o, 0);
      ticks(1);
      check("R5 floor, 60 ticks", shutdown_o, 1);
   endtask

   task automatic t_unpowered;
      powered_i = 1'b0;
      class_i = 3'd3; iout_i = 10'd400;
      @(negedge clk);
      ticks(100);
      check("R9 no trip unpowered", shutdown_o, 0);
      powered_i = 1'b1;
      @(negedge clk);
      ticks(59);
      check("R9 timer started from zero", shutdown_o, 0);
      ticks(1);
      check("R9 trip after full window", shutdown_o, 1);
   endtask

   task automatic t_inrush_guard;
      repower(3'd4, 10'd500, 10'd0);
      check("R10 low setpoint at power on", ilim_code_o, 425);
      ilim_active_i = 1'b1;
      ticks(59);
      check("R11 no guard during window", shutdown_o, 0);
      check("R10 low setpoint in window", ilim_code_o, 425);
      ticks(1);
      check("R10 high setpoint after window", ilim_code_o, 885);
      check("R11 still no trip", shutdown_o, 0);
      ticks(14);
      check("R6 14 limit ticks", shutdown_o, 0);
      ilim_active_i = 1'b0;
      @(negedge clk);
      ilim_active_i = 1'b1;
      ticks(14);
      check("R6 restart after gap", shutdown_o, 0);
      ticks(1);
      check("R6 trip on 15th", shutdown_o, 1);
      check("R6 cause limit", cause_o, 2);
   endtask

   task automatic t_guard_other;
      repower(3'd3, 10'd500, 10'd0);
      ticks(60);
      check("R10 class 3 setpoint", ilim_code_o, 425);
      ilim_active_i = 1'b1;
      ticks(100);
      check("R7 limit ignored class 3", shutdown_o, 0);
      check("R7 cause clear", cause_o, 0);
      ilim_active_i = 1'b0;
   endtask

   initial begin
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      t_reset();
      t_threshold();
      t_timeout_edge();
      t_sticky();
      t_leak();
      t_floor();
      t_unpowered();
      t_inrush_guard();
      t_guard_other();
      done = 1'b1;
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_checks++;
         n_fail++;
         $display("FAIL watchdog: actual 0 expected 1 (run completed)");
         $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
         $finish;
      end
   end
endmodule